// File: doc/BRIEF.md
# Privileged Status and Interrupt-Enable Register Unit

This unit holds the machine-level status word of a processor hart together with the interrupt-enable word, the interrupt delegation word and the exception delegation word. Software reaches all of them through a single write/read port: a register select picks the target, a write strobe commits a full-width value, and the read data returns the selected register, or a view of it, in the same cycle. Every write is filtered per field, so only legal contents are ever stored.

Two of the selectable registers have no storage of their own. They are masked windows onto machine state. The supervisor status view shows and updates only the supervisor-visible status fields. The supervisor interrupt-enable view shows and updates only the enable bits whose interrupts have been delegated. Two configuration inputs state whether supervisor mode and user mode exist, and this decides which previous-privilege values a status write may store. When a status update alters a field that affects address translation, a one-cycle flush request is raised for the translation cache.

Top module: `priv_status_unit`

## Requirements
- R1: A status write (select 0) updates only bits 1, 3, 5, 7, 8, 11, 12, 13, 14, 17, 18 and 19. Every other status bit ignores the written data and keeps its value.
- R2: The previous-privilege field (status bits 12:11) keeps its old value when the written code is 2, when it is 1 and supervisor mode is absent, or when it is 0 and user mode is absent. The other writable fields still update in that write.
- R3: After any status update, a non-zero floating-point state field (bits 14:13) is stored as 3.
- R4: After any status update, bit 31 equals 1 exactly when bits 14:13 are 3 or bits 16:15 are 3.
- R5: The flush output is high for exactly the one cycle after a status update (select 0 or 1) that changes any of bits 12:11, 17, 18 or 19 of the stored status. Otherwise it is low.
- R6: The interrupt-enable word (select 2) accepts writes only to bits 1, 3, 5, 7, 9 and 11. Interrupt delegation (select 4) accepts only bits 1, 5 and 9. Exception delegation (select 5) accepts only bits 0 to 13 and 15. All other bits ignore the write.
- R7: The supervisor status view (select 1) reads the status word ANDed with the mask 0x800DE133 (bits 0, 1, 4, 5, 8, 13 to 16, 18, 19, 31). A write to it replaces only the bits under that mask and then follows R1 to R4.
- R8: The supervisor interrupt-enable view (select 3) reads enable ANDed with interrupt delegation. A write to it changes only the enable bits that are set in delegation, still limited by R6.
- R9: After reset, every register reads zero and the flush output is low.
- R10: Selects 6 and 7 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_mode_en | input | 1 | Supervisor mode exists |
| usr_mode_en | input | 1 | User mode exists |
| wr_en | input | 1 | Commit wr_data to the selected register this cycle |
| reg_sel | input | 3 | Register select (0 status, 1 supervisor status view, 2 enable, 3 supervisor enable view, 4 interrupt delegation, 5 exception delegation) |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Selected register or view, combinational |
| status_o | output | 32 | Stored status word |
| int_en_o | output | 32 | Stored interrupt-enable word |
| int_dlg_o | output | 32 | Stored interrupt delegation word |
| exc_dlg_o | output | 32 | Stored exception delegation word |
| tlb_flush_o | output | 1 | One-cycle translation flush request |

## Verification
The bench sweeps every combination of mode configuration, requested previous-privilege code and floating-point state code, with all-zero, all-one and pseudo-random fill in the other bits, through both status selects. A design that checks the privilege code against the wrong mode input would store code 1 or 0 where it must be kept. A design that tests the raw write data for the flush, rather than the stored change, would pulse on writes that were discarded. The delegation and enable sweeps change delegation between writes through the supervisor enable view, so a view that writes through a fixed mask, or one that skips the enable mask, leaves wrong bits behind. Selects 6 and 7 are written with all ones to show that no register moves.

// File: rtl/psu_pkg.sv
package psu_pkg;

    localparam int XLEN  = 32;
    localparam int SEL_W = 3;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_MSTAT  = 3'd0,
        SEL_SSTAT  = 3'd1,
        SEL_IEN    = 3'd2,
        SEL_SIEN   = 3'd3,
        SEL_IDLG   = 3'd4,
        SEL_EDLG   = 3'd5
    } sel_e;

    // status field positions
    localparam int P_UIE  = 0;
    localparam int P_SIE  = 1;
    localparam int P_MIE  = 3;
    localparam int P_UPIE = 4;
    localparam int P_SPIE = 5;
    localparam int P_MPIE = 7;
    localparam int P_SPP  = 8;
    localparam int P_MPP  = 11;
    localparam int P_FS   = 13;
    localparam int P_XS   = 15;
    localparam int P_MPRV = 17;
    localparam int P_SUM  = 18;
    localparam int P_MXR  = 19;
    localparam int P_SD   = XLEN - 1;

    // interrupt bit positions
    localparam int P_SSI = 1;
    localparam int P_MSI = 3;
    localparam int P_STI = 5;
    localparam int P_MTI = 7;
    localparam int P_SEI = 9;
    localparam int P_MEI = 11;

    localparam word_t ONE       = word_t'(1);
    localparam word_t PAIR      = word_t'(3);
    localparam word_t MPP_MASK  = PAIR << P_MPP;
    localparam word_t FS_MASK   = PAIR << P_FS;
    localparam word_t XS_MASK   = PAIR << P_XS;

    localparam word_t STAT_WR_MASK =
        (ONE << P_SIE) | (ONE << P_MIE) | (ONE << P_SPIE) | (ONE << P_MPIE) |
        (ONE << P_SPP) | MPP_MASK | FS_MASK | (ONE << P_MPRV) |
        (ONE << P_SUM) | (ONE << P_MXR);

    localparam word_t SVIEW_MASK =
        (ONE << P_UIE) | (ONE << P_SIE) | (ONE << P_UPIE) | (ONE << P_SPIE) |
        (ONE << P_SPP) | FS_MASK | XS_MASK | (ONE << P_SUM) |
        (ONE << P_MXR) | (ONE << P_SD);

    localparam word_t FLUSH_MASK =
        MPP_MASK | (ONE << P_MPRV) | (ONE << P_SUM) | (ONE << P_MXR);

    localparam word_t S_INT_MASK = (ONE << P_SSI) | (ONE << P_STI) | (ONE << P_SEI);
    localparam word_t M_INT_MASK = (ONE << P_MSI) | (ONE << P_MTI) | (ONE << P_MEI);
    localparam word_t IEN_MASK   = S_INT_MASK | M_INT_MASK;

    // causes 0..13 and 15 may be delegated
    localparam int    EXC_LOW_N = 14;
    localparam int    EXC_HIGH  = 15;
    localparam word_t EDLG_MASK = ((ONE << EXC_LOW_N) - ONE) | (ONE << EXC_HIGH);

    typedef struct packed {
        word_t status;
        word_t ien;
        word_t idlg;
        word_t edlg;
        logic  flush;
    } state_t;

endpackage

// File: rtl/field_merge.sv
module field_merge #(
    parameter int W = 32
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] new_val,
    input  logic [W-1:0] sel_mask,
    output logic [W-1:0] merged
);
    always_comb begin
        merged = (old_val & ~sel_mask) | (new_val & sel_mask);
    end
endmodule

// File: rtl/status_filter.sv
module status_filter
    import psu_pkg::*;
(
    input  word_t cur,
    input  word_t wval,
    input  logic  sup_ok,
    input  logic  usr_ok,
    output word_t nxt,
    output logic  ctl_changed
);
    logic [1:0] mpp_req;
    logic       mpp_legal;
    word_t      eff_mask;
    word_t      blended;

    always_comb begin
        mpp_req   = wval[P_MPP +: 2];
        mpp_legal = !((mpp_req == 2'd2) ||
                      (mpp_req == 2'd1 && !sup_ok) ||
                      (mpp_req == 2'd0 && !usr_ok));
        eff_mask  = mpp_legal ? STAT_WR_MASK : (STAT_WR_MASK & ~MPP_MASK);
    end

    field_merge #(.W(XLEN)) u_merge (
        .old_val (cur),
        .new_val (wval),
        .sel_mask(eff_mask),
        .merged  (blended)
    );

    always_comb begin
        nxt = blended;
        if (nxt[P_FS +: 2] != 2'b00) begin
            nxt[P_FS +: 2] = 2'b11;
        end
        nxt[P_SD] = (nxt[P_FS +: 2] == 2'b11) || (nxt[P_XS +: 2] == 2'b11);
        ctl_changed = ((cur ^ nxt) & FLUSH_MASK) != '0;
    end
endmodule

// File: rtl/priv_status_unit.sv
module priv_status_unit
    import psu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sup_mode_en,
    input  logic             usr_mode_en,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [XLEN-1:0]  wr_data,
    output logic [XLEN-1:0]  rd_data,
    output logic [XLEN-1:0]  status_o,
    output logic [XLEN-1:0]  int_en_o,
    output logic [XLEN-1:0]  int_dlg_o,
    output logic [XLEN-1:0]  exc_dlg_o,
    output logic             tlb_flush_o
);
    state_t state_d, state_q;

    word_t sview_wr, stat_src, stat_new;
    word_t sien_wr, ien_src, ien_new;
    word_t idlg_new, edlg_new;
    logic  ctl_chg;

    // supervisor status window: splice masked bits into current status
    field_merge #(.W(XLEN)) u_sview (
        .old_val (state_q.status),
        .new_val (wr_data),
        .sel_mask(SVIEW_MASK),
        .merged  (sview_wr)
    );

    always_comb begin
        stat_src = (reg_sel == SEL_SSTAT) ? sview_wr : wr_data;
        ien_src  = (reg_sel == SEL_SIEN)  ? sien_wr  : wr_data;
    end

    status_filter u_filter (
        .cur        (state_q.status),
        .wval       (stat_src),
        .sup_ok     (sup_mode_en),
        .usr_ok     (usr_mode_en),
        .nxt        (stat_new),
        .ctl_changed(ctl_chg)
    );

    // supervisor enable window: only delegated bits move
    field_merge #(.W(XLEN)) u_sien (
        .old_val (state_q.ien),
        .new_val (wr_data),
        .sel_mask(state_q.idlg),
        .merged  (sien_wr)
    );

    field_merge #(.W(XLEN)) u_ien (
        .old_val (state_q.ien),
        .new_val (ien_src),
        .sel_mask(IEN_MASK),
        .merged  (ien_new)
    );

    field_merge #(.W(XLEN)) u_idlg (
        .old_val (state_q.idlg),
        .new_val (wr_data),
        .sel_mask(S_INT_MASK),
        .merged  (idlg_new)
    );

    field_merge #(.W(XLEN)) u_edlg (
        .old_val (state_q.edlg),
        .new_val (wr_data),
        .sel_mask(EDLG_MASK),
        .merged  (edlg_new)
    );

    always_comb begin
        state_d       = state_q;
        state_d.flush = 1'b0;
        if (wr_en) begin
            case (reg_sel)
                SEL_MSTAT, SEL_SSTAT: begin
                    state_d.status = stat_new;
                    state_d.flush  = ctl_chg;
                end
                SEL_IEN, SEL_SIEN: state_d.ien  = ien_new;
                SEL_IDLG:          state_d.idlg = idlg_new;
                SEL_EDLG:          state_d.edlg = edlg_new;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_MSTAT: rd_data = state_q.status;
            SEL_SSTAT: rd_data = state_q.status & SVIEW_MASK;
            SEL_IEN:   rd_data = state_q.ien;
            SEL_SIEN:  rd_data = state_q.ien & state_q.idlg;
            SEL_IDLG:  rd_data = state_q.idlg;
            SEL_EDLG:  rd_data = state_q.edlg;
            default:   rd_data = '0;
        endcase
    end

    assign status_o    = state_q.status;
    assign int_en_o    = state_q.ien;
    assign int_dlg_o   = state_q.idlg;
    assign exc_dlg_o   = state_q.edlg;
    assign tlb_flush_o = state_q.flush;

endmodule

// File: rtl/priv_status_unit_chk.sv
module priv_status_unit_chk
    import psu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] reg_sel,
    input logic [XLEN-1:0]  status_o,
    input logic [XLEN-1:0]  int_en_o,
    input logic [XLEN-1:0]  int_dlg_o,
    input logic [XLEN-1:0]  exc_dlg_o,
    input logic             tlb_flush_o
);
    AST_MPP_NOT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[P_MPP +: 2] != 2'd2); // R2

    AST_FS_OFF_OR_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[P_FS +: 2] == 2'b00 || status_o[P_FS +: 2] == 2'b11); // R3

    AST_SD_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[P_SD] == ((status_o[P_FS +: 2] == 2'b11) || (status_o[P_XS +: 2] == 2'b11))); // R4

    AST_FLUSH_AFTER_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_o |-> $past(wr_en && (reg_sel == SEL_MSTAT || reg_sel == SEL_SSTAT))); // R5

    AST_ENABLE_LEGAL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en_o & ~IEN_MASK) == '0 && (int_dlg_o & ~S_INT_MASK) == '0 &&
        (exc_dlg_o & ~EDLG_MASK) == '0); // R6

    AST_SIEN_KEEPS_UNDELEGATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_SIEN) |=>
        ((int_en_o & ~int_dlg_o) == ($past(int_en_o) & ~$past(int_dlg_o)))); // R8

    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(status_o) && $stable(int_en_o) &&
                    $stable(int_dlg_o) && $stable(exc_dlg_o))); // R10
endmodule

bind priv_status_unit priv_status_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .reg_sel    (reg_sel),
    .status_o   (status_o),
    .int_en_o   (int_en_o),
    .int_dlg_o  (int_dlg_o),
    .exc_dlg_o  (exc_dlg_o),
    .tlb_flush_o(tlb_flush_o)
);

// File: tb/priv_status_unit_test.sv
module priv_status_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sup_mode_en = 1'b1;
    logic        usr_mode_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data, status_o, int_en_o, int_dlg_o, exc_dlg_o;
    logic        tlb_flush_o;

    int checks = 0;
    int fails  = 0;

    logic [31:0] e_stat = 0, e_ien = 0, e_idlg = 0, e_edlg = 0;
    logic        e_flush = 0;

    always #5 clk = ~clk;

    priv_status_unit uut (
        .clk(clk), .rst_n(rst_n), .sup_mode_en(sup_mode_en), .usr_mode_en(usr_mode_en),
        .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
        .status_o(status_o), .int_en_o(int_en_o), .int_dlg_o(int_dlg_o),
        .exc_dlg_o(exc_dlg_o), .tlb_flush_o(tlb_flush_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // status write per R1..R4 with hard-coded field constants
    function automatic logic [31:0] model_stat(input logic [31:0] old, input logic [31:0] v,
                                                input logic hs, input logic hu);
        logic [31:0] m = 32'h000E79AA;
        logic [31:0] n;
        if (v[12:11] == 2'd2 || (v[12:11] == 2'd1 && !hs) || (v[12:11] == 2'd0 && !hu))
            m = m & ~32'h0000_1800;
        n = (old & ~m) | (v & m);
        if (n[14:13] != 2'd0) n[14:13] = 2'd3;
        n[31] = (n[14:13] == 2'd3) || (n[16:15] == 2'd3);
        return n;
    endfunction

    function automatic logic [31:0] lfsr(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    task automatic read_all();
        for (int s = 0; s < 8; s++) begin
            reg_sel = 3'(s);
            #1;
            case (s)
                0: check("R1 status read", rd_data, e_stat);
                1: check("R7 supervisor status view", rd_data, e_stat & 32'h800DE133);
                2: check("R6 enable read", rd_data, e_ien);
                3: check("R8 supervisor enable view", rd_data, e_ien & e_idlg);
                4: check("R6 interrupt delegation read", rd_data, e_idlg);
                5: check("R6 exception delegation read", rd_data, e_edlg);
                default: check("R10 unused select reads zero", rd_data, 32'd0);
            endcase
        end
        check("R1 status port", status_o, e_stat);
        check("R6 enable port", int_en_o, e_ien);
        check("R6 int delegation port", int_dlg_o, e_idlg);
        check("R6 exc delegation port", exc_dlg_o, e_edlg);
    endtask

    task automatic do_write(input int sel, input logic [31:0] v);
        logic [31:0] pre, nv;
        @(negedge clk);
        wr_en = 1'b1; reg_sel = 3'(sel); wr_data = v;
        e_flush = 1'b0;
        case (sel)
            0, 1: begin
                pre = e_stat;
                nv  = (sel == 1) ? ((e_stat & ~32'h800DE133) | (v & 32'h800DE133)) : v;
                e_stat = model_stat(e_stat, nv, sup_mode_en, usr_mode_en);
                e_flush = ((pre ^ e_stat) & 32'h000E1800) != 0;
            end
            2: e_ien  = (e_ien & ~32'h0000_0AAA) | (v & 32'h0000_0AAA);
            3: e_ien  = (e_ien & ~(e_idlg & 32'h0AAA)) | (v & e_idlg & 32'h0AAA);
            4: e_idlg = (e_idlg & ~32'h0000_0222) | (v & 32'h0000_0222);
            5: e_edlg = (e_edlg & ~32'h0000_BFFF) | (v & 32'h0000_BFFF);
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b0;
        check("R5 flush after write", {31'd0, tlb_flush_o}, {31'd0, e_flush});
        read_all();
        check("R5 flush single cycle", {31'd0, tlb_flush_o}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rnd = 32'h1234_5678;
        logic [31:0] fill, v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset flush", {31'd0, tlb_flush_o}, 32'd0);
        read_all();

        // status sweep: config x requested privilege x fp state x fill
        for (int cfg = 0; cfg < 4; cfg++) begin
            sup_mode_en = cfg[1];
            usr_mode_en = cfg[0];
            for (int mp = 0; mp < 4; mp++) begin
                for (int fs = 0; fs < 4; fs++) begin
                    for (int pat = 0; pat < 3; pat++) begin
                        rnd  = lfsr(rnd);
                        fill = (pat == 0) ? 32'd0 : (pat == 1) ? 32'hFFFF_FFFF : rnd;
                        v = fill;
                        v[12:11] = 2'(mp);
                        v[14:13] = 2'(fs);
                        do_write(0, v);
                        check("R2 privilege field", {30'd0, status_o[12:11]}, {30'd0, e_stat[12:11]});
                        check("R3 fp state field", {30'd0, status_o[14:13]}, {30'd0, (fs != 0) ? 2'd3 : 2'd0});
                        check("R4 summary bit", {31'd0, status_o[31]}, {31'd0, fs != 0});
                        do_write(1, ~v);
                        check("R7 view write keeps privilege", {30'd0, status_o[12:11]}, {30'd0, e_stat[12:11]});
                    end
                end
            end
        end

        // R2 explicit: code 2 never stored, other fields still move
        sup_mode_en = 1'b1; usr_mode_en = 1'b1;
        do_write(0, 32'h0000_1808);
        do_write(0, 32'h0000_1000 | 32'h0000_0002);
        check("R2 reserved code discarded", {30'd0, status_o[12:11]}, 32'd3);
        check("R2 other field updated", {31'd0, status_o[1]}, 32'd1);

        // enable / delegation sweeps
        for (int k = 0; k < 48; k++) begin
            rnd = lfsr(rnd);
            do_write(4, rnd);
            rnd = lfsr(rnd);
            do_write(2, rnd);
            rnd = lfsr(rnd);
            do_write(3, rnd);
            do_write(3, ~rnd);
            rnd = lfsr(rnd);
            do_write(5, rnd);
            do_write(6, 32'hFFFF_FFFF);
            do_write(7, 32'hFFFF_FFFF);
        end
        do_write(2, 32'hFFFF_FFFF);
        check("R6 enable all ones", int_en_o, 32'h0000_0AAA);
        do_write(5, 32'hFFFF_FFFF);
        check("R6 exc delegation all ones", exc_dlg_o, 32'h0000_BFFF);
        do_write(4, 32'd0);
        do_write(3, 32'd0);
        check("R8 no delegation, view write inert", int_en_o, 32'h0000_0AAA);

        // reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        e_stat = 0; e_ien = 0; e_idlg = 0; e_edlg = 0;
        check("R9 reset flush", {31'd0, tlb_flush_o}, 32'd0);
        read_all();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule